// File: doc/BRIEF.md
# Protected-Region Lock Register

This block is one 8-bit configuration register with its own write mask. Firmware uses it in two steps to protect a fixed low-memory region that holds the system-management save area. First it probes for the feature by writing a query code. The register answers with an "in RAM" code and narrows its write mask so that only the lock bit stays writable. Firmware then sets the lock bit. From then on the value and the mask are frozen until reset. A locked region is decoded on a small access port:

- Accesses made outside system-management mode land in an all-ones sink.
- Accesses made in system-management mode are steered to a private RAM window.

A static feature strap turns the mechanism off. With the strap low the register behaves as a plain read/write byte and the region is never protected.

The configuration write port and the region access port are valid/ready streams. Both ready signals are held high, so the block never applies back-pressure and every beat offered is accepted in the cycle it is offered. Each accepted access produces exactly one response beat in the following cycle, and the response side has no ready. The register value, the write mask and the two enables are plain level outputs.

Top module: `smb_lock_top`

## Requirements
- R1: After reset the register value is 0x00, the write mask is 0xFF, and both enables (`sink_en`, `smm_win_en`) are low.
- R2: With the strap high and no probe yet, a write of 0xFF makes the value 0x01 and the mask 0x02, and leaves both enables low.
- R3: With the strap high and no probe yet, any write other than 0xFF is discarded. This includes 0x02. The value stays 0x00 and the mask stays 0xFF.
- R4: After the probe, a write with bit 1 clear changes only bit 1 of the value (so it stays 0x01), and both enables stay low.
- R5: After the probe, a write with bit 1 set forces the value to exactly 0x02, clears the mask to 0x00, and raises both enables.
- R6: Once locked, no write changes the value (0x02), the mask (0x00) or the enables; only reset clears the lock.
- R7: With the strap low, each write is stored as written and the mask stays 0xFF. A write of 0xFF does not probe, and a write with bit 1 set does not lock. Both enables stay low.
- R8: While locked, a non-SMM access inside the region is sunk (`rsp_sunk`=1). A sunk read returns all ones, and a sunk write returns data 0.
- R9: While locked, an SMM access inside the region is steered to the window (`rsp_smm_win`=1, `rsp_sunk`=0).
- R10: An access outside the region, or any access while unlocked, has `rsp_sunk`=0 and `rsp_smm_win`=0, with data 0.
- R11: Both ready outputs are always high. A write takes effect on the value, mask and enables in the cycle after it is accepted. An access is judged with the lock state of the cycle it is accepted in, and its response is valid in the next cycle.
- R12: The region spans [`REGION_BASE`, `REGION_BASE`+`REGION_SIZE`). The default is 0x30000 to 0x4FFFF inclusive, so both end addresses are inside and the addresses one step beyond each end are outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Feature strap; 0 disables probing and locking |
| wr_valid | input | 1 | Configuration write offered |
| wr_ready | output | 1 | Always 1 |
| wr_data | input | 8 | Byte written to the register |
| reg_value | output | 8 | Current register value |
| reg_wmask | output | 8 | Current write mask |
| sink_en | output | 1 | Non-SMM all-ones sink enabled |
| smm_win_en | output | 1 | SMM-only RAM window enabled |
| acc_valid | input | 1 | Region access offered |
| acc_ready | output | 1 | Always 1 |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_smm | input | 1 | Access made in system-management mode |
| acc_addr | input | 32 | Access address |
| rsp_valid | output | 1 | Response beat, one cycle after an accepted access |
| rsp_sunk | output | 1 | Access absorbed by the sink |
| rsp_smm_win | output | 1 | Access steered to the SMM window |
| rsp_data | output | 32 | All ones for a sunk read, else 0 |

## Verification
A write that sets the lock bit and a non-SMM access to the region can be accepted on the same clock edge. The bench offers both beats in one cycle. It expects that access to pass unsunk, because it is judged with the state from before the lock. It expects the enables to be high afterwards. A second identical access in the following cycle must then be sunk and return all ones, which shows that the lock takes effect exactly one cycle after the write.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_PROBED = 2'd1,
    ST_LOCKED = 2'd2
  } smb_state_e;

  typedef struct packed {
    logic sunk;
    logic win;
  } smb_route_t;
endpackage

// File: rtl/smb_lock_fsm.sv
module smb_lock_fsm
  import smb_pkg::*;
#(
  parameter int          REG_W       = 8,
  parameter logic [7:0]  QUERY_CODE  = 8'hFF,
  parameter logic [7:0]  ANSWER_CODE = 8'h01,
  parameter int          LOCK_BIT    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en,
  input  logic             wr_fire,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] value,
  output logic [REG_W-1:0] wmask,
  output logic             locked
);
  localparam logic [REG_W-1:0] LOCK_MASK = REG_W'(1) << LOCK_BIT;
  localparam logic [REG_W-1:0] ALL_ONES  = '1;
  localparam logic [REG_W-1:0] QUERY_W   = REG_W'(QUERY_CODE);
  localparam logic [REG_W-1:0] ANSWER_W  = REG_W'(ANSWER_CODE);

  smb_state_e       state_q, state_d;
  logic [REG_W-1:0] value_q, value_d;
  logic [REG_W-1:0] merged;

  // Mask follows the state: full before the probe, lock bit only after it,
  // nothing once locked.
  always_comb begin
    unique case (state_q)
      ST_PROBED: wmask = LOCK_MASK;
      ST_LOCKED: wmask = '0;
      default:   wmask = ALL_ONES;
    endcase
  end

  // Plain masked write, the default handling for any register byte.
  assign merged = (value_q & ~wmask) | (wr_data & wmask);

  always_comb begin
    state_d = state_q;
    value_d = value_q;
    if (wr_fire) begin
      if (!feat_en) begin
        value_d = merged;
      end else begin
        unique case (state_q)
          ST_OPEN: begin
            if (merged == QUERY_W) begin
              value_d = ANSWER_W;
              state_d = ST_PROBED;
            end else begin
              value_d = '0;
            end
          end
          ST_PROBED: begin
            if (merged[LOCK_BIT]) begin
              value_d = LOCK_MASK;
              state_d = ST_LOCKED;
            end else begin
              value_d = merged;
            end
          end
          default: begin
            value_d = value_q;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      value_q <= '0;
    end else begin
      state_q <= state_d;
      value_q <= value_d;
    end
  end

  assign value  = value_q;
  assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/smb_region_decode.sv
module smb_region_decode #(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W:0] LO = {1'b0, REGION_BASE};
  localparam logic [ADDR_W:0] HI = {1'b0, REGION_BASE} + {1'b0, REGION_SIZE};

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr};
  assign hit    = (addr_x >= LO) && (addr_x < HI);
endmodule

// File: rtl/smb_access_steer.sv
module smb_access_steer
  import smb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              acc_write,
  input  logic              acc_smm,
  input  logic              hit,
  input  logic              sink_on,
  input  logic              win_on,
  output logic              rsp_valid,
  output logic              rsp_sunk,
  output logic              rsp_smm_win,
  output logic [DATA_W-1:0] rsp_data
);
  smb_route_t        route;
  logic [DATA_W-1:0] data_d;
  logic              valid_q;
  smb_route_t        route_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    route.sunk = acc_fire && hit && sink_on && !acc_smm;
    route.win  = acc_fire && hit && win_on && acc_smm;
    data_d     = (route.sunk && !acc_write) ? '1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      route_q <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= acc_fire;
      route_q <= route;
      data_q  <= data_d;
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_sunk    = route_q.sunk;
  assign rsp_smm_win = route_q.win;
  assign rsp_data    = data_q;
endmodule

// File: rtl/smb_lock_top.sv
module smb_lock_top #(
  parameter int                REG_W       = 8,
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [7:0]        QUERY_CODE  = 8'hFF,
  parameter logic [7:0]        ANSWER_CODE = 8'h01,
  parameter int                LOCK_BIT    = 1,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  reg_value,
  output logic [REG_W-1:0]  reg_wmask,
  output logic              sink_en,
  output logic              smm_win_en,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic              acc_smm,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rsp_valid,
  output logic              rsp_sunk,
  output logic              rsp_smm_win,
  output logic [DATA_W-1:0] rsp_data
);
  logic locked;
  logic hit;
  logic wr_fire;
  logic acc_fire;

  assign wr_ready  = 1'b1;
  assign acc_ready = 1'b1;
  assign wr_fire   = wr_valid && wr_ready;
  assign acc_fire  = acc_valid && acc_ready;

  smb_lock_fsm #(
    .REG_W      (REG_W),
    .QUERY_CODE (QUERY_CODE),
    .ANSWER_CODE(ANSWER_CODE),
    .LOCK_BIT   (LOCK_BIT)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .feat_en(feat_en),
    .wr_fire(wr_fire),
    .wr_data(wr_data),
    .value  (reg_value),
    .wmask  (reg_wmask),
    .locked (locked)
  );

  assign sink_en    = locked && feat_en;
  assign smm_win_en = locked && feat_en;

  smb_region_decode #(
    .ADDR_W     (ADDR_W),
    .REGION_BASE(REGION_BASE),
    .REGION_SIZE(REGION_SIZE)
  ) u_dec (
    .addr(acc_addr),
    .hit (hit)
  );

  smb_access_steer #(
    .DATA_W(DATA_W)
  ) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_fire   (acc_fire),
    .acc_write  (acc_write),
    .acc_smm    (acc_smm),
    .hit        (hit),
    .sink_on    (sink_en),
    .win_on     (smm_win_en),
    .rsp_valid  (rsp_valid),
    .rsp_sunk   (rsp_sunk),
    .rsp_smm_win(rsp_smm_win),
    .rsp_data   (rsp_data)
  );
endmodule

// File: rtl/smb_lock_chk.sv
module smb_lock_chk #(
  parameter int REG_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feat_en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  reg_value,
  input logic [REG_W-1:0]  reg_wmask,
  input logic              sink_en,
  input logic              smm_win_en,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              rsp_valid,
  input logic              rsp_sunk,
  input logic              rsp_smm_win,
  input logic [DATA_W-1:0] rsp_data
);
  logic wf;
  assign wf = wr_valid && wr_ready;

  p_query_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wf && feat_en && reg_wmask == 8'hFF && wr_data == 8'hFF
    |=> reg_value == 8'h01 && reg_wmask == 8'h02 && !sink_en);

  p_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wf && feat_en && reg_wmask == 8'hFF && wr_data != 8'hFF
    |=> reg_value == 8'h00 && reg_wmask == 8'hFF);

  p_lock_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sink_en) |-> $past(wf) && $past(wr_data[1]) && reg_value == 8'h02);

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sink_en && feat_en |=> sink_en && smm_win_en && reg_value == 8'h02 && reg_wmask == 8'h00);

  p_strap_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |-> !sink_en && !smm_win_en && reg_wmask == 8'hFF);

  p_sink_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_sunk && !$past(acc_write) |-> rsp_data == '1);

  p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_sunk && rsp_smm_win));

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind smb_lock_top smb_lock_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .feat_en    (feat_en),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_data    (wr_data),
  .reg_value  (reg_value),
  .reg_wmask  (reg_wmask),
  .sink_en    (sink_en),
  .smm_win_en (smm_win_en),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .rsp_valid  (rsp_valid),
  .rsp_sunk   (rsp_sunk),
  .rsp_smm_win(rsp_smm_win),
  .rsp_data   (rsp_data)
);

// File: tb/smb_lock_top_tb.sv
module smb_lock_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic [7:0]  reg_value, reg_wmask;
  logic        sink_en, smm_win_en;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic        acc_write = 1'b0;
  logic        acc_smm = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        rsp_valid, rsp_sunk, rsp_smm_win;
  logic [31:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  smb_lock_top u_dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .reg_value(reg_value), .reg_wmask(reg_wmask),
    .sink_en(sink_en), .smm_win_en(smm_win_en),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_smm(acc_smm), .acc_addr(acc_addr),
    .rsp_valid(rsp_valid), .rsp_sunk(rsp_sunk), .rsp_smm_win(rsp_smm_win),
    .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [7:0] v, input logic [7:0] m,
                         input logic en);
    chk(req, "value", {24'd0, reg_value}, {24'd0, v});
    chk(req, "wmask", {24'd0, reg_wmask}, {24'd0, m});
    chk(req, "sink_en", {31'd0, sink_en}, {31'd0, en});
    chk(req, "smm_win_en", {31'd0, smm_win_en}, {31'd0, en});
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    feat_en = strap;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic smm,
                        input logic w, input logic e_sunk, input logic e_win,
                        input logic [31:0] e_data);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr = a;
    acc_smm = smm;
    acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(req, "rsp_sunk", {31'd0, rsp_sunk}, {31'd0, e_sunk});
    chk(req, "rsp_smm_win", {31'd0, rsp_smm_win}, {31'd0, e_win});
    chk(req, "rsp_data", rsp_data, e_data);
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk_reg("R1", 8'h00, 8'hFF, 1'b0);
    chk("R11", "wr_ready", {31'd0, wr_ready}, 32'd1);
    chk("R11", "acc_ready", {31'd0, acc_ready}, 32'd1);
  endtask

  task automatic t_handshake;
    do_reset(1'b1);
    wr(8'h5A);  chk_reg("R3", 8'h00, 8'hFF, 1'b0);
    wr(8'h02);  chk_reg("R3", 8'h00, 8'hFF, 1'b0);
    wr(8'hFF);  chk_reg("R2", 8'h01, 8'h02, 1'b0);
    wr(8'hFD);  chk_reg("R4", 8'h01, 8'h02, 1'b0);
    wr(8'hFF);  chk_reg("R5", 8'h02, 8'h00, 1'b1);
    wr(8'h00);  chk_reg("R6", 8'h02, 8'h00, 1'b1);
    wr(8'hFF);  chk_reg("R6", 8'h02, 8'h00, 1'b1);
    do_reset(1'b1);
    chk_reg("R6", 8'h00, 8'hFF, 1'b0);
  endtask

  task automatic t_unlocked_access;
    do_reset(1'b1);
    access("R10", 32'h0003_8000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    access("R10", 32'h0003_8000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_locked_access;
    do_reset(1'b1);
    wr(8'hFF);
    wr(8'h02);
    chk_reg("R5", 8'h02, 8'h00, 1'b1);
    access("R8",  32'h0003_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    access("R8",  32'h0004_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0);
    access("R9",  32'h0004_0000, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0);
    access("R12", 32'h0002_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    access("R12", 32'h0005_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    access("R12", 32'h0004_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_same_cycle;
    do_reset(1'b1);
    wr(8'hFF);
    @(negedge clk);
    wr_valid = 1'b1;  wr_data = 8'h02;
    acc_valid = 1'b1; acc_addr = 32'h0003_1000; acc_smm = 1'b0; acc_write = 1'b0;
    @(negedge clk);
    wr_valid = 1'b0;
    acc_valid = 1'b0;
    chk("R11", "rsp_sunk same cycle", {31'd0, rsp_sunk}, 32'd0);
    chk("R11", "rsp_data same cycle", rsp_data, 32'h0);
    chk("R11", "sink_en after", {31'd0, sink_en}, 32'd1);
    access("R11", 32'h0003_1000, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_strap_off;
    do_reset(1'b0);
    chk_reg("R7", 8'h00, 8'hFF, 1'b0);
    wr(8'h5A);  chk_reg("R7", 8'h5A, 8'hFF, 1'b0);
    wr(8'hFF);  chk_reg("R7", 8'hFF, 8'hFF, 1'b0);
    wr(8'h02);  chk_reg("R7", 8'h02, 8'hFF, 1'b0);
    access("R7", 32'h0003_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_handshake();
        t_unlocked_access();
        t_locked_access();
        t_same_cycle();
        t_strap_off();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule